// File: doc/BRIEF.md
# PCM Transmit Serial Port

This block serializes one 8-bit companded PCM code per frame. A producer writes the code into a holding register with a load strobe, and the port sends it MSB first on a serial data line. A separate output-enable line tells the pad logic when to drive that serial line. The block follows an external bit clock and a transmit frame-sync input. Both inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are detected in the system clock domain. The system clock must run at least 8 times faster than the fastest bit clock. Bit clocks from 64 kHz to 2.048 MHz are supported.

The port works out for itself whether the frame sync is a short pulse or a long pulse. A short pulse lasts one bit period. A long pulse lasts three or more bit periods. The enable timing changes with the mode:

- **Short mode.** The port arms on a falling bit-clock edge that sees frame sync high.
- **Long mode.** Transmission starts at whichever comes later: the frame-sync rise or a bit-clock rise. It ends at whichever comes later: the end of the eighth bit or the frame-sync fall.

The mode is decided when frame sync drops. It takes effect from the following frame.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset the enable output and the data output are 0, and `long_mode` is 0 (0 = short-frame mode, 1 = long-frame mode).
- R2: In short mode, a falling bit-clock edge with frame sync high arms the port. The next rising bit-clock edge raises `tx_oe` and puts bit 7 (the sign bit) of the code on `tx_data`.
- R3: While enabled, each later rising bit-clock edge moves the next lower bit onto `tx_data`. Bits 7 down to 0 go out on eight consecutive rising edges. After bit 0, the line keeps bit 0 until it is disabled.
- R4: In short mode, `tx_oe` drops at the first falling bit-clock edge after the rising edge that sent bit 0.
- R5: On each frame-sync fall, the port counts the falling bit-clock edges seen while frame sync was high. Three or more select long mode. Exactly one selects short mode. The new mode applies from the next frame, never to the frame in progress.
- R6: A frame-sync pulse that spans exactly two falling bit-clock edges keeps the previous mode.
- R7: In long mode, a frame-sync rise while the bit clock is high enables the output at once. A rise while the bit clock is low enables it at the next rising bit-clock edge. Bit 7 is sent first in both cases, and that enabling edge counts as the first of the eight.
- R8: In long mode, `tx_oe` drops at the later of two events: the falling bit-clock edge after bit 0 was sent, or the frame-sync fall.
- R9: The code written with `code_load` is the one sent in the next frame. A load made while a frame is being sent does not change that frame; it is sent in the frame after.
- R10: Whenever `tx_oe` is 0, `tx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | CODE_W | Code to be sent in the next frame |
| code_load | input | 1 | Single-cycle strobe that captures `code_in` |
| bclk_in | input | 1 | Asynchronous transmit bit clock |
| fsync_in | input | 1 | Asynchronous transmit frame sync |
| tx_data | output | 1 | Serial data, MSB first, 0 while disabled |
| tx_oe | output | 1 | Enable for the external three-state driver |
| long_mode | output | 1 | Detected frame-sync mode, 1 = long |

## Verification
Two events are made to land in the same system clock cycle.

- **Enable.** The frame sync is driven high on the very edge where the bit clock rises. In long mode the frame-sync rise and the bit-clock rise are then seen together, and the bench expects the sign bit at once. It compares this with frames whose sync rises in the middle of the high phase (same result) and in the middle of the low phase (enable waits for the next rise).
- **Disable.** Long frame-sync pulses end on a rising bit-clock edge after the eighth bit. The frame-sync fall that releases the tail-hold is then checked against the mode update that the same fall triggers. Each half bit period is sampled and compared with the expected enable and data values.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    typedef enum logic {
        MODE_SHORT = 1'b0,
        MODE_LONG  = 1'b1
    } fs_mode_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARM   = 2'd1,
        TX_SHIFT = 2'd2,
        TX_TAIL  = 2'd3
    } tx_state_e;

    // One synchronized input: its level and single-cycle edge strobes.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_ev_t;

    // Control part of the transmit sequencer.
    typedef struct packed {
        tx_state_e st;
        fs_mode_e  fmode;
        logic      oe;
    } tx_ctl_t;

    localparam int SYNC_DEPTH_DEF = 2;
    localparam int LONG_MIN_DEF   = 3;

    // Decide the mode from the count of falling bit-clock edges seen
    // while frame sync was high (count saturates at long_min).
    function automatic fs_mode_e classify_mode(input int unsigned falls,
                                               input int unsigned long_min,
                                               input fs_mode_e    cur);
        if (falls >= long_min)
            return MODE_LONG;
        else if (falls == 1)
            return MODE_SHORT;
        else
            return cur;
    endfunction

endpackage

// File: rtl/pcm_tx_edge.sv
module pcm_tx_edge
    import pcm_tx_pkg::*;
#(
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     async_in,
    output edge_ev_t ev
);
    logic [SYNC_DEPTH-1:0] chain;
    logic                  last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[SYNC_DEPTH-2:0], async_in};
            last_q <= chain[SYNC_DEPTH-1];
        end
    end

    always_comb begin
        ev.level = chain[SYNC_DEPTH-1];
        ev.rise  = chain[SYNC_DEPTH-1] & ~last_q;
        ev.fall  = ~chain[SYNC_DEPTH-1] & last_q;
    end
endmodule

// File: rtl/pcm_tx_mode_det.sv
module pcm_tx_mode_det
    import pcm_tx_pkg::*;
#(
    parameter int LONG_MIN = LONG_MIN_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_fall,
    input  logic     fs_level,
    input  logic     fs_rise,
    input  logic     fs_fall,
    output fs_mode_e mode
);
    localparam int CW = $clog2(LONG_MIN + 1);

    logic [CW-1:0] fall_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_cnt <= '0;
            mode     <= MODE_SHORT;
        end else begin
            if (fs_rise) begin
                fall_cnt <= bclk_fall ? CW'(1) : '0;
            end else if (bclk_fall && fs_level && (fall_cnt < CW'(LONG_MIN))) begin
                fall_cnt <= fall_cnt + CW'(1);
            end
            if (fs_fall) begin
                mode <= classify_mode(int'(fall_cnt), LONG_MIN, mode);
            end
        end
    end
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
    import pcm_tx_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_load,
    input  logic              bclk_level,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              fs_level,
    input  logic              fs_rise,
    input  fs_mode_e          mode,
    output logic              oe,
    output logic              sd_bit
);
    localparam int CNT_W = $clog2(CODE_W + 1);

    tx_ctl_t           ctl_q, ctl_d;
    logic [CODE_W-1:0] hold_q;
    logic [CODE_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              start_now;
    logic              shift_now;

    always_comb begin
        ctl_d     = ctl_q;
        start_now = 1'b0;
        shift_now = 1'b0;
        unique case (ctl_q.st)
            TX_IDLE: begin
                if (mode == MODE_SHORT) begin
                    if (bclk_fall && fs_level) begin
                        ctl_d.st    = TX_ARM;
                        ctl_d.fmode = MODE_SHORT;
                    end
                end else if (fs_rise) begin
                    ctl_d.fmode = MODE_LONG;
                    if (bclk_level) start_now = 1'b1;
                    else            ctl_d.st  = TX_ARM;
                end
            end
            TX_ARM: begin
                if (bclk_rise) start_now = 1'b1;
            end
            TX_SHIFT: begin
                if (bclk_rise && (cnt_q < CNT_W'(CODE_W))) begin
                    shift_now = 1'b1;
                end else if (bclk_fall && (cnt_q == CNT_W'(CODE_W))) begin
                    if ((ctl_q.fmode == MODE_SHORT) || !fs_level) begin
                        ctl_d.st = TX_IDLE;
                        ctl_d.oe = 1'b0;
                    end else begin
                        ctl_d.st = TX_TAIL;
                    end
                end
            end
            TX_TAIL: begin
                if (!fs_level) begin
                    ctl_d.st = TX_IDLE;
                    ctl_d.oe = 1'b0;
                end
            end
            default: ctl_d.st = TX_IDLE;
        endcase
        if (start_now) begin
            ctl_d.st = TX_SHIFT;
            ctl_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{st: TX_IDLE, fmode: MODE_SHORT, oe: 1'b0};
            hold_q <= '0;
            sreg_q <= '0;
            cnt_q  <= '0;
        end else begin
            ctl_q <= ctl_d;
            if (code_load) hold_q <= code_in;
            if (start_now) begin
                sreg_q <= hold_q;
                cnt_q  <= CNT_W'(1);
            end else if (shift_now) begin
                sreg_q <= {sreg_q[CODE_W-2:0], 1'b0};
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign oe     = ctl_q.oe;
    assign sd_bit = ctl_q.oe & sreg_q[CODE_W-1];
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
    import pcm_tx_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF,
    parameter int LONG_MIN   = LONG_MIN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_load,
    input  logic              bclk_in,
    input  logic              fsync_in,
    output logic              tx_data,
    output logic              tx_oe,
    output logic              long_mode
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    edge_ev_t        ev [N_IN];
    edge_ev_t        ev_bclk;
    edge_ev_t        ev_fs;
    fs_mode_e        mode;

    assign raw_in = {fsync_in, bclk_in};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
        pcm_tx_edge #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw_in[gi]),
            .ev       (ev[gi])
        );
    end

    assign ev_bclk = ev[0];
    assign ev_fs   = ev[1];

    pcm_tx_mode_det #(.LONG_MIN(LONG_MIN)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .bclk_fall (ev_bclk.fall),
        .fs_level  (ev_fs.level),
        .fs_rise   (ev_fs.rise),
        .fs_fall   (ev_fs.fall),
        .mode      (mode)
    );

    pcm_tx_shifter #(.CODE_W(CODE_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .code_in    (code_in),
        .code_load  (code_load),
        .bclk_level (ev_bclk.level),
        .bclk_rise  (ev_bclk.rise),
        .bclk_fall  (ev_bclk.fall),
        .fs_level   (ev_fs.level),
        .fs_rise    (ev_fs.rise),
        .mode       (mode),
        .oe         (tx_oe),
        .sd_bit     (tx_data)
    );

    assign long_mode = (mode == MODE_LONG);
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk (
    input logic clk,
    input logic rst,
    input logic tx_oe,
    input logic tx_data,
    input logic long_mode,
    input logic bclk_rise,
    input logic bclk_fall,
    input logic fs_rise,
    input logic fs_fall
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_oe && !tx_data && !long_mode));

    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |-> !tx_data);

    // R2 and R7: enable only follows a bit-clock rise or a frame-sync rise
    assert_oe_rise_on_edge_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_oe) |-> ($past(bclk_rise) || $past(fs_rise)));

    // R4 and R8: disable only follows a bit-clock fall or a frame-sync fall
    assert_oe_fall_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_oe) |-> ($past(bclk_fall) || $past(fs_fall)));

    assert_data_moves_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_oe && $past(tx_oe) && !$stable(tx_data)) |-> $past(bclk_rise));

    assert_mode_on_fs_fall_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(long_mode) |-> $past(fs_fall));
endmodule

bind pcm_tx_port pcm_tx_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_oe     (tx_oe),
    .tx_data   (tx_data),
    .long_mode (long_mode),
    .bclk_rise (ev_bclk.rise),
    .bclk_fall (ev_bclk.fall),
    .fs_rise   (ev_fs.rise),
    .fs_fall   (ev_fs.fall)
);

// File: tb/tb_pcm_tx_port.sv
module tb_pcm_tx_port;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] code_in;
    logic       code_load;
    logic       bclk_in;
    logic       fsync_in;
    logic       tx_data;
    logic       tx_oe;
    logic       long_mode;

    int         n_checks = 0;
    int         n_fail   = 0;
    bit         exp_long = 1'b0;
    logic [7:0] exp_hold = 8'h00;

    always #10 clk = ~clk;

    pcm_tx_port dut (
        .clk       (clk),
        .rst       (rst),
        .code_in   (code_in),
        .code_load (code_load),
        .bclk_in   (bclk_in),
        .fsync_in  (fsync_in),
        .tx_data   (tx_data),
        .tx_oe     (tx_oe),
        .long_mode (long_mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One half bit period = 8 system cycles; sampled in the last one.
    task automatic half(input int h, input bit fs_edge, input bit mid, input bit fs_mid,
                        input bit ld, input logic [7:0] ld_code,
                        output bit s_oe, output bit s_d);
        @(negedge clk);
        bclk_in  = (h % 2 == 0);
        fsync_in = fs_edge;
        @(negedge clk);
        if (ld) begin
            code_in   = ld_code;
            code_load = 1'b1;
        end
        @(negedge clk);
        code_load = 1'b0;
        @(negedge clk);
        if (mid) fsync_in = fs_mid;
        repeat (4) @(negedge clk);
        s_oe = tx_oe;
        s_d  = tx_data;
    endtask

    task automatic idle(input int periods, input bit ld, input logic [7:0] c);
        bit so, sd;
        for (int p = 0; p < periods; p++) begin
            for (int hh = 0; hh < 2; hh++) begin
                half(hh, 1'b0, 1'b0, 1'b0, ld && p == 0 && hh == 0, c, so, sd);
                chk("R10", "idle oe", so, 0);
                chk("R10", "idle data", sd, 0);
            end
        end
        if (ld) exp_hold = c;
    endtask

    function automatic int enable_half(input bit lng, input int r);
        if (lng) return (r == 0) ? 0 : 2;
        return (r == 0) ? 2 : 4;
    endfunction

    function automatic int disable_half(input bit lng, input int on, input int d);
        if (lng) return (on + 15 > d) ? on + 15 : d;
        return on + 15;
    endfunction

    // r: half where sync rises (0 = high phase, 1 = low phase); rmid: rises mid-half;
    // d: even half where sync drops on a rising edge; midload: load a new code at half 5.
    task automatic frame(input int r, input bit rmid, input int d, input bit midload);
        bit         lng = exp_long;
        int         on  = enable_half(lng, r);
        int         off = disable_half(lng, on, d);
        int         last_h;
        int         falls;
        logic [7:0] used = exp_hold;
        logic [7:0] nxt  = 8'($urandom);
        bit         so, sd;
        last_h = ((off > d) ? off : d) + 2;
        if (last_h % 2 == 0) last_h++;
        for (int h = 0; h <= last_h; h++) begin
            bit fs_e = ((h > r) || (h == r && !rmid)) && (h < d);
            bit e_oe = (h >= on) && (h < off);
            int idx;
            bit e_d;
            half(h, fs_e, (h == r) && rmid, 1'b1, midload && h == 5, nxt, so, sd);
            if (h <= on) chk(lng ? "R7" : "R2", "enable", so, e_oe);
            else         chk(lng ? "R8" : "R4", "enable", so, e_oe);
            idx = (h - on) / 2;
            if (idx > 7) idx = 7;
            e_d = e_oe ? used[7 - idx] : 1'b0;
            if (!e_oe)        chk("R10", "data while off", sd, e_d);
            else if (midload) chk("R9", "data bit", sd, e_d);
            else              chk("R3", "data bit", sd, e_d);
        end
        if (midload) exp_hold = nxt;
        falls = (r == 0) ? d / 2 : (d - 2) / 2;
        if (falls >= 3)      exp_long = 1'b1;
        else if (falls == 1) exp_long = 1'b0;
        chk((falls == 2) ? "R6" : "R5", "mode", long_mode, exp_long);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit rr;
        int lens [6] = '{1, 2, 3, 4, 7, 10};
        void'($urandom(32'd2718));
        rst = 1'b1; code_in = 8'h00; code_load = 1'b0; bclk_in = 1'b0; fsync_in = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "oe after reset", tx_oe, 0);
        chk("R1", "data after reset", tx_data, 0);
        chk("R1", "mode after reset", long_mode, 0);

        idle(2, 1'b1, 8'hA5);
        frame(0, 1'b0, 2, 1'b0);   // short pulse in short mode (R2, R4)
        idle(1, 1'b1, 8'h3C);
        frame(0, 1'b0, 8, 1'b1);   // long pulse, short timing; mode -> long (R5, R9)
        idle(1, 1'b0, 8'h00);
        frame(0, 1'b0, 6, 1'b0);   // long: sync and bclk rise together (R7)
        idle(1, 1'b1, 8'hF0);
        frame(1, 1'b1, 8, 1'b0);   // long: sync rises in low phase (R7)
        idle(1, 1'b1, 8'h81);
        frame(0, 1'b1, 20, 1'b0);  // long: sync rises mid high phase, held past bit 0 (R8)
        idle(1, 1'b0, 8'h00);
        frame(0, 1'b0, 4, 1'b0);   // two-period pulse keeps long (R6)
        idle(1, 1'b1, 8'h5A);
        frame(0, 1'b0, 2, 1'b0);   // short pulse in long timing; mode -> short (R5)
        idle(1, 1'b0, 8'h00);
        frame(1, 1'b1, 6, 1'b0);   // two-period pulse keeps short (R6)
        idle(1, 1'b0, 8'h00);

        for (int i = 0; i < 30; i++) begin
            int  r    = int'($urandom % 2);
            bit  rmid = (r == 1) ? 1'b1 : 1'($urandom % 2);
            int  len  = lens[$urandom % 6];
            if (!exp_long && len == 10) len = 7;
            rr = 1'($urandom % 2);
            idle(1, rr, 8'($urandom));
            frame(r, rmid, (r == 0) ? 2 * len : 2 * len + 2, 1'($urandom % 2));
        end
        idle(1, 1'b0, 8'h00);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule